// File: doc/BRIEF.md
# Interleaved Three-Level Sequence Detector

This block turns the filtered output of a three-level frequency demodulator back into binary data. Each incoming sample carries one of three nominal levels: zero, plus a full-scale constant, or minus it. A data 0 is sent as the zero level. A data 1 is sent as a nonzero level, and within each interleaved substream successive ones take alternating signs. Samples are numbered from reset. Samples with even numbers form one substream and samples with odd numbers form the other. Each substream goes to its own four-state maximum-likelihood sequence detector, which updates once every other sample. The decoded bits are merged back into a single stream with one output bit per input sample.

Each detector tracks the last two precoded symbols of its substream as its trellis state. Branch costs are the absolute distance between the sample and the level a transition expects. Accumulated costs are rebased to a minimum of zero after every step. Survivor bits are kept by register exchange, and the output bit is tapped at the selected depth from the survivor of the lowest-cost state. One control input bypasses the detectors and uses a symmetric two-threshold slicer instead. A change of the depth code clears both detectors.

Top module: `vit3_detector`

## Requirements
- R1: While reset is asserted and afterwards until a sample has been accepted, `outValid` and `outBit` are 0.
- R2: Every accepted input sample (`inValid` high on a clock edge) produces exactly one output strobe two clock edges later, and no output strobe is produced otherwise.
- R3: With `viterbiEn` low, the output bit is 1 exactly when the magnitude of the sample is strictly greater than the 7-bit unsigned threshold `sliceThr`. For example, a threshold of 50 slices 50 and −50 to 0, and slices 51, −51 and −128 to 1.
- R4: Line coding: data 0 is level 0 and data 1 is level ±`LEVEL`. Within each substream, the signs of consecutive ones alternate.
- R5: Samples with even index since reset or flush feed one detector and samples with odd index feed the other. The two substreams keep their sign alternation separately, so a stream of all ones shaped as +,+,−,−,+,+ decodes as all ones.
- R6: With `viterbiEn` high and noiseless input, the output strobe for sample n carries the data bit of sample n−2L, where L is the selected depth.
- R7: `pathCode` selects the depth L: 0 selects 4, 1 selects 6, 2 selects 8 and 3 selects 32.
- R8: An isolated sample that breaks the sign alternation of its substream is corrected in detector mode. A zero-data sample received at +40, lying between ones sent at +64 and −64, decodes as 0.
- R9: The survivor memory starts cleared after reset. A change of `pathCode` also clears it and the path costs, so outputs read 0 until new data has propagated to depth L, whatever data came before.
- R10: Path costs are rebased every step, so a constant offset of +8 on every sample over 3000 samples does not corrupt the decoded data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input sample strobe |
| inSample | input | W | Signed demodulator sample |
| viterbiEn | input | 1 | 1: sequence detection, 0: threshold slicer |
| sliceThr | input | 7 | Unsigned slicer threshold magnitude |
| pathCode | input | 2 | Survivor depth select |
| outValid | output | 1 | Output bit strobe |
| outBit | output | 1 | Recovered data bit |

## Verification
The detector is driven with several repeating data words at every depth setting. An all-ones stream is included; it is legal only when the two substreams alternate signs independently, so it separates correct interleaving from a single merged trellis. One stream has a single alternation-breaking sample, where detector mode and slicer mode must give different bits. Another carries a constant offset over thousands of samples, which reveals any failure to rebase the path costs. Slicer mode is tried with a spread of pseudo-random amplitudes and with values exactly at the threshold and one step beyond it. A depth change after a stream of ones shows whether stale survivors leak into later output.

// File: rtl/vit3_pkg.sv
package vit3_pkg;

  localparam int unsigned DEPTH_MAX = 32;
  localparam int unsigned SURV_W    = DEPTH_MAX + 1;
  localparam int unsigned TAP_W     = $clog2(SURV_W);

  typedef struct packed {
    logic flush;
    logic updEven;
    logic updOdd;
    logic phase;
    logic valid;
  } vit3_ctrl_t;

  function automatic logic [TAP_W-1:0] depthOf(input logic [1:0] code);
    case (code)
      2'd0:    depthOf = TAP_W'(4);
      2'd1:    depthOf = TAP_W'(6);
      2'd2:    depthOf = TAP_W'(8);
      default: depthOf = TAP_W'(DEPTH_MAX);
    endcase
  endfunction

endpackage

// File: rtl/vit3_ctrl.sv
module vit3_ctrl
  import vit3_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic [1:0] pathCode,
  output vit3_ctrl_t ctrl
);

  logic [1:0] lastCode;
  logic       phase;
  logic       validD;
  logic       phaseD;
  logic       codeChg;

  assign codeChg = (pathCode != lastCode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lastCode <= 2'd0;
      phase    <= 1'b0;
      validD   <= 1'b0;
      phaseD   <= 1'b0;
    end else begin
      lastCode <= pathCode;
      validD   <= inValid;
      phaseD   <= phase;
      if (codeChg)      phase <= 1'b0;
      else if (inValid) phase <= ~phase;
    end
  end

  always_comb begin
    ctrl.flush   = codeChg;
    ctrl.updEven = inValid & ~phase & ~codeChg;
    ctrl.updOdd  = inValid &  phase & ~codeChg;
    ctrl.phase   = phaseD;
    ctrl.valid   = validD;
  end

endmodule

// File: rtl/vit3_trellis.sv
module vit3_trellis
  import vit3_pkg::*;
#(
  parameter int W     = 8,
  parameter int LEVEL = 64,
  parameter int PM_W  = W + 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                upd,
  input  logic signed [W-1:0] sample,
  input  logic [1:0]          pathCode,
  output logic                bestBit
);

  localparam int BM_W = W + 1;
  localparam logic signed [W+1:0] POS = (W+2)'(LEVEL);
  localparam logic signed [W+1:0] NEG = -(W+2)'(LEVEL);

  logic [PM_W-1:0]   pm     [4];
  logic [SURV_W-1:0] surv   [4];
  logic [PM_W-1:0]   cand   [4];
  logic [1:0]        srcSt  [4];
  logic [BM_W-1:0]   bm     [4];
  logic [PM_W-1:0]   minC;
  logic [1:0]        best;
  logic [TAP_W-1:0]  tap;
  logic signed [W+1:0] xExt;

  assign xExt = {{2{sample[W-1]}}, sample};
  assign tap  = depthOf(pathCode);

  // state {p[k-1], p[k-2]}; next state {p, p[k-1]}; expected level p - p[k-1]
  always_comb begin
    for (int n = 0; n < 4; n++) begin
      logic [1:0]          nn;
      logic [1:0]          pa;
      logic [1:0]          pb;
      logic signed [W+1:0] expV;
      logic signed [W+1:0] diff;
      nn    = 2'(n);
      pa    = {nn[0], 1'b0};
      pb    = {nn[0], 1'b1};
      expV  = (nn == 2'd2) ? POS : (nn == 2'd1) ? NEG : '0;
      diff  = xExt - expV;
      bm[n] = diff[W+1] ? BM_W'(-diff) : BM_W'(diff);
      srcSt[n] = (pm[pb] < pm[pa]) ? pb : pa;
      cand[n]  = pm[srcSt[n]] + PM_W'(bm[n]);
    end
    minC = cand[0];
    for (int n = 1; n < 4; n++)
      if (cand[n] < minC) minC = cand[n];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < 4; n++) begin
        pm[n]   <= '0;
        surv[n] <= '0;
      end
    end else if (flush) begin
      for (int n = 0; n < 4; n++) begin
        pm[n]   <= '0;
        surv[n] <= '0;
      end
    end else if (upd) begin
      for (int n = 0; n < 4; n++) begin
        logic [1:0] nn;
        nn = 2'(n);
        pm[n]   <= cand[n] - minC;
        surv[n] <= {surv[srcSt[n]][SURV_W-2:0], nn[1] ^ nn[0]};
      end
    end
  end

  always_comb begin
    best = 2'd0;
    for (int n = 3; n >= 0; n--)
      if (pm[n] == '0) best = 2'(n);
  end

  assign bestBit = surv[best][tap];

endmodule

// File: rtl/vit3_datapath.sv
module vit3_datapath
  import vit3_pkg::*;
#(
  parameter int W     = 8,
  parameter int LEVEL = 64,
  parameter int THR_W = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  vit3_ctrl_t          ctrl,
  input  logic signed [W-1:0] inSample,
  input  logic                viterbiEn,
  input  logic [THR_W-1:0]    sliceThr,
  input  logic [1:0]          pathCode,
  output logic                outValid,
  output logic                outBit
);

  logic [1:0] bestBit;
  logic [1:0] updSel;
  logic [W:0] mag;
  logic       sliceD;

  assign updSel = {ctrl.updOdd, ctrl.updEven};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_lane
      vit3_trellis #(.W(W), .LEVEL(LEVEL)) u_trellis (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (ctrl.flush),
        .upd      (updSel[g]),
        .sample   (inSample),
        .pathCode (pathCode),
        .bestBit  (bestBit[g])
      );
    end
  endgenerate

  assign mag = inSample[W-1] ? (W+1)'(-{inSample[W-1], inSample})
                             : (W+1)'({inSample[W-1], inSample});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sliceD   <= 1'b0;
      outValid <= 1'b0;
      outBit   <= 1'b0;
    end else begin
      sliceD   <= (mag > (W+1)'(sliceThr));
      outValid <= ctrl.valid;
      outBit   <= ctrl.valid & (viterbiEn ? bestBit[ctrl.phase] : sliceD);
    end
  end

endmodule

// File: rtl/vit3_detector.sv
module vit3_detector
  import vit3_pkg::*;
#(
  parameter int W     = 8,
  parameter int LEVEL = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inValid,
  input  logic signed [W-1:0] inSample,
  input  logic                viterbiEn,
  input  logic [6:0]          sliceThr,
  input  logic [1:0]          pathCode,
  output logic                outValid,
  output logic                outBit
);

  vit3_ctrl_t ctrl;

  vit3_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .pathCode (pathCode),
    .ctrl     (ctrl)
  );

  vit3_datapath #(.W(W), .LEVEL(LEVEL), .THR_W(7)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .inSample  (inSample),
    .viterbiEn (viterbiEn),
    .sliceThr  (sliceThr),
    .pathCode  (pathCode),
    .outValid  (outValid),
    .outBit    (outBit)
  );

endmodule

// File: rtl/vit3_checker.sv
module vit3_checker #(
  parameter int W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                inValid,
  input logic signed [W-1:0] inSample,
  input logic                viterbiEn,
  input logic [6:0]          sliceThr,
  input logic                outValid,
  input logic                outBit
);

  logic [1:0] age;
  logic [1:0] outCnt;
  logic [W:0] magC;

  assign magC = inSample[W-1] ? (W+1)'(-{inSample[W-1], inSample})
                              : (W+1)'({inSample[W-1], inSample});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age    <= 2'd0;
      outCnt <= 2'd0;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      if (outValid && outCnt != 2'd3) outCnt <= outCnt + 2'd1;
    end
  end

  // R1: quiet output right after reset
  a_r1_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
    (age < 2'd2) |-> (!outValid && !outBit));

  // R2: one strobe per accepted sample, two edges later
  a_r2_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (outValid == $past(inValid, 2)));

  // R3: slicer mode compares magnitude with threshold
  a_r3_bypass_slice: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && outValid && !$past(viterbiEn))
      |-> (outBit == ($past(magC, 2) > (W+1)'($past(sliceThr, 2)))));

  // R9: survivors start cleared, so the first detector outputs are 0
  a_r9_clear_start: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outCnt < 2'd2 && $past(viterbiEn)) |-> !outBit);

endmodule

bind vit3_detector vit3_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .inValid   (inValid),
  .inSample  (inSample),
  .viterbiEn (viterbiEn),
  .sliceThr  (sliceThr),
  .outValid  (outValid),
  .outBit    (outBit)
);

// File: tb/sim_vit3_detector.sv
module sim_vit3_detector;

  localparam int W   = 8;
  localparam int LEV = 64;
  localparam int NMAX = 4000;

  // {viterbiEn, pathCode[1:0], sliceThr[6:0], pattern[31:0]}
  localparam int NVEC = 6;
  localparam logic [41:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 7'd0,  32'hA5C3_0F96},
    {1'b1, 2'd1, 7'd0,  32'h0000_FFFF},
    {1'b1, 2'd2, 7'd0,  32'hFFFF_FFFF},
    {1'b1, 2'd3, 7'd0,  32'h1357_9BDF},
    {1'b0, 2'd0, 7'd32, 32'h0},
    {1'b0, 2'd2, 7'd0,  32'h0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic signed [W-1:0] inSample = '0;
  logic viterbiEn = 1'b1;
  logic [6:0] sliceThr = '0;
  logic [1:0] pathCode = 2'd0;
  logic outValid;
  logic outBit;

  int total = 0;
  int bad = 0;
  logic outQ [$];
  logic signed [W-1:0] smp [NMAX];
  logic expB [NMAX];
  logic dataB [NMAX];

  always #2 clk = ~clk;

  vit3_detector #(.W(W), .LEVEL(LEV)) u0 (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inSample(inSample),
    .viterbiEn(viterbiEn), .sliceThr(sliceThr), .pathCode(pathCode),
    .outValid(outValid), .outBit(outBit)
  );

  always @(negedge clk) if (outValid) outQ.push_back(outBit);

  task automatic check(input logic ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int depthL(input logic [1:0] c);
    case (c) 2'd0: return 4; 2'd1: return 6; 2'd2: return 8; default: return 32; endcase
  endfunction

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0; inValid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    outQ.delete();
  endtask

  task automatic sendAll(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b1; inSample = smp[i];
    end
    @(negedge clk);
    inValid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // precode data per substream: 0 -> 0, 1 -> alternating +/-LEV
  task automatic encode(input int n, input int bias);
    logic neg [2];
    neg[0] = 1'b0; neg[1] = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (dataB[i]) begin
        smp[i] = neg[i%2] ? W'(-LEV + bias) : W'(LEV + bias);
        neg[i%2] = ~neg[i%2];
      end else smp[i] = W'(bias);
    end
  endtask

  task automatic compareVit(input int n, input int L, input string req);
    check(outQ.size() == n, "R2 strobe count", outQ.size(), n);
    for (int i = 2*L + 4; i < n && i < outQ.size(); i++)
      check(outQ[i] == dataB[i-2*L], req, int'(outQ[i]), int'(dataB[i-2*L]));
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0 && outBit == 1'b0, "R1 reset", int'({outValid, outBit}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(outValid == 1'b0, "R1 idle after reset", int'(outValid), 0);

    // table walk: R4 R5 R6 R7 (detector) and R3 (slicer)
    for (int v = 0; v < NVEC; v++) begin
      logic [41:0] e;
      int n;
      e = VEC[v];
      pathCode = e[40:39];
      viterbiEn = e[41];
      sliceThr = e[38:32];
      doReset();
      n = 128;
      if (e[41]) begin
        for (int i = 0; i < n; i++) dataB[i] = e[i%32];
        encode(n, 0);
        sendAll(n);
        compareVit(n, depthL(e[40:39]), "R6 R7 R4 R5 table");
      end else begin
        for (int i = 0; i < n; i++) begin
          int x;
          x = ((i*73 + 11) % 256) - 128;
          smp[i] = W'(x);
          expB[i] = ((x < 0 ? -x : x) > int'(e[38:32]));
        end
        sendAll(n);
        check(outQ.size() == n, "R2 strobe count", outQ.size(), n);
        for (int i = 0; i < n && i < outQ.size(); i++)
          check(outQ[i] == expB[i], "R3 table", int'(outQ[i]), int'(expB[i]));
      end
    end

    // R2: exact two-edge delay
    viterbiEn = 1'b0; sliceThr = 7'd10; pathCode = 2'd0;
    doReset();
    @(negedge clk); inValid = 1'b1; inSample = 8'sd100;
    @(negedge clk); inValid = 1'b0;
    check(outValid == 1'b0, "R2 one edge", int'(outValid), 0);
    @(negedge clk);
    check(outValid == 1'b1 && outBit == 1'b1, "R2 two edges", int'({outValid, outBit}), 3);
    @(negedge clk);
    check(outValid == 1'b0, "R2 single strobe", int'(outValid), 0);

    // R3 boundaries
    sliceThr = 7'd50;
    doReset();
    smp[0] = 8'sd50; smp[1] = 8'sd51; smp[2] = -8'sd50; smp[3] = -8'sd51; smp[4] = -8'sd128;
    expB[0] = 0; expB[1] = 1; expB[2] = 0; expB[3] = 1; expB[4] = 1;
    sendAll(5);
    for (int i = 0; i < 5 && i < outQ.size(); i++)
      check(outQ[i] == expB[i], "R3 boundary", int'(outQ[i]), int'(expB[i]));
    sliceThr = 7'd0;
    doReset();
    smp[0] = 8'sd0; smp[1] = 8'sd1;
    sendAll(2);
    check(outQ.size() == 2 && outQ[0] == 1'b0 && outQ[1] == 1'b1, "R3 zero threshold",
          outQ.size() == 2 ? int'({outQ[0], outQ[1]}) : -1, 1);

    // R8: isolated alternation violation
    for (int i = 0; i < 64; i++) dataB[i] = (((i * 7) % 5) < 2);
    dataB[38] = 1'b1; dataB[40] = 1'b0; dataB[42] = 1'b1;
    encode(64, 0);
    smp[40] = (smp[38] > 0) ? 8'sd40 : -8'sd40;
    viterbiEn = 1'b1; pathCode = 2'd0;
    doReset();
    sendAll(64);
    compareVit(64, 4, "R8 corrected stream");
    if (outQ.size() > 48) check(outQ[48] == 1'b0, "R8 bad sample decoded", int'(outQ[48]), 0);
    viterbiEn = 1'b0; sliceThr = 7'd20;
    doReset();
    sendAll(64);
    if (outQ.size() > 40) check(outQ[40] == 1'b1, "R3 slicer sees bad sample", int'(outQ[40]), 1);

    // R9: depth change flushes survivors
    viterbiEn = 1'b1; pathCode = 2'd3;
    doReset();
    for (int i = 0; i < 101; i++) dataB[i] = 1'b1;
    encode(101, 0);
    sendAll(101);
    outQ.delete();
    pathCode = 2'd0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 40; i++) dataB[i] = 1'b0;
    encode(40, 0);
    sendAll(40);
    check(outQ.size() == 40, "R9 strobe count", outQ.size(), 40);
    for (int i = 0; i < 40 && i < outQ.size(); i++)
      check(outQ[i] == 1'b0, "R9 flushed output", int'(outQ[i]), 0);

    // R10: constant offset over a long run
    viterbiEn = 1'b1; pathCode = 2'd2;
    doReset();
    begin
      logic [15:0] lf;
      lf = 16'hACE1;
      for (int i = 0; i < 3000; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        dataB[i] = lf[0];
      end
    end
    encode(3000, 8);
    sendAll(3000);
    compareVit(3000, 8, "R10 offset long run");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule